// File: doc/BRIEF.md
# Stationary-Result Counterflow Convolver

This block computes a finite convolution y_i = w_0·x_i + w_1·x_{i+1} + … + w_{TAPS-1}·x_{i+TAPS-1} on a linear chain of TAPS identical cells. Samples enter the first cell and move one cell per clock toward the last. Weights enter the last cell and move one cell per clock toward the first. Each cell owns one accumulator, and every partial result stays in its cell until it is complete. When a sample and a weight sit in the same cell, the cell adds their product to its accumulator.

The weight stream repeats w_0 … w_{TAPS-1} without end and is driven by the surrounding controller. The w_0 entry of each pass carries a tag. When a cell holds the tag, it hands its finished sum to a result chain and starts a new sum. The result chain has one latch per cell and moves toward the last cell. No shared bus is used.

Both streams use the same beat: one slot every second cycle. For an even TAPS, one extra entry register on the weight side keeps the meeting points aligned. Finished results leave the last cell in natural order, one every two cycles.

Top module: `sr_counterflow_conv`

## Requirements
- R1: A sample taken on a beat walks from cell 0 toward cell TAPS-1, and a weight walks from cell TAPS-1 toward cell 0, each one cell per cycle. For an even TAPS the weight input has one extra register stage, so for any TAPS sample slot j and weight slot s meet in cell s-j+floor(TAPS/2).
- R2: Inputs are offered only on beats, which are even cycles counted from the first edge after reset release. Sample slot j and weight slot j are offered on the same beat. Weight slot s carries w[s mod TAPS], and its tag is 1 exactly when s mod TAPS is 0. Weights are never invalid while the block runs.
- R3: Result y_i equals the sum over m from 0 to TAPS-1 of w[m]·x_{i+m}. All values are two's complement, and the sum is exact within ACC_W bits.
- R4: A cell adds a product only when both the sample valid and the weight valid are set in that cell. An invalid sample slot contributes zero to every result that would use it.
- R5: A tagged weight makes its cell release the old sum. The accumulator is then reloaded with the current product if a valid sample is present in that cycle, and with zero otherwise.
- R6: y_i is released only when sample slot i was valid. When slot i is invalid, no result appears in the output slot of y_i.
- R7: Counting edge 0 as the one that captures slot 0, y_i is presented on res_vld/res_dat right after edge 2i+3·TAPS. No result valid appears in any other cycle, so two results are never on consecutive cycles.
- R8: Each cell has one result latch. A cell never releases a result in a cycle when a result from the cell before it is moving into its latch.
- R9: Reset clears every cell, and res_vld is 0 during reset and on the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | Sample slot carries data |
| smp_dat | input | SMP_W | Signed sample |
| wgt_vld | input | 1 | Weight slot carries data |
| wgt_tag | input | 1 | Weight is w[0], the start of a pass |
| wgt_dat | input | WGT_W | Signed weight |
| res_vld | output | 1 | Finished result present |
| res_dat | output | ACC_W | Signed result |

## Verification
Sample slot i is captured on edge 2i. Its result y_i must therefore be on the port just after edge 2i+3·TAPS, which is TAPS+2 edges after the last sample that y_i uses. The bench keeps its own edge count from reset release and builds the expected valid and value for every edge from the weight and sample tables. After each edge it samples both instances (TAPS=4 and TAPS=3) at the falling clock edge. Any early, late, missing or extra result therefore shows up as a mismatch in that exact cycle.

// File: rtl/cnv_pkg.sv
package cnv_pkg;
    parameter int SMP_W = 8;
    parameter int WGT_W = 8;
    parameter int ACC_W = 20;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic signed [WGT_W-1:0] wgt_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    typedef struct packed {
        logic vld;
        smp_t dat;
    } smp_beat_t;

    typedef struct packed {
        logic vld;
        logic tag;
        wgt_t dat;
    } wgt_beat_t;

    typedef struct packed {
        logic vld;
        acc_t dat;
    } res_beat_t;

    typedef struct packed {
        acc_t acc;
        logic armed;
    } mac_st_t;

    typedef struct packed {
        smp_beat_t x;
        wgt_beat_t w;
        res_beat_t o;
    } lane_st_t;
endpackage

// File: rtl/cnv_mac.sv
// Multiply-accumulate state of one cell: it sums products while a sum is
// open, and on a tagged weight it closes the old sum and starts a new one.
module cnv_mac
    import cnv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  smp_beat_t x_i,
    input  wgt_beat_t w_i,
    output acc_t      acc_o,
    output logic      emit_o,
    output logic      meet_o,
    output logic      tag_o
);
    mac_st_t st_d, st_q;
    acc_t    prod;
    logic    meet;
    logic    tag;

    always_comb begin
        meet = x_i.vld & w_i.vld;
        tag  = w_i.vld & w_i.tag;
        prod = acc_t'(x_i.dat) * acc_t'(w_i.dat);
        st_d = st_q;
        if (tag) begin
            // restart: the first term of the new sum may already be here
            st_d.acc   = meet ? prod : '0;
            st_d.armed = x_i.vld;
        end else if (meet) begin
            st_d.acc = st_q.acc + prod;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign emit_o = tag & st_q.armed;
    assign meet_o = meet;
    assign tag_o  = tag;
endmodule

// File: rtl/cnv_cell.sv
// One cell: a sample register, a weight register, the result latch on the
// output chain, and the accumulator.
module cnv_cell
    import cnv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  smp_beat_t smp_i,
    input  wgt_beat_t wgt_i,
    input  res_beat_t res_i,
    output smp_beat_t smp_o,
    output wgt_beat_t wgt_o,
    output res_beat_t res_o,
    output logic      emit_o,
    output logic      meet_o,
    output logic      tag_o,
    output acc_t      acc_o
);
    lane_st_t st_d, st_q;
    acc_t     acc;
    logic     emit;

    cnv_mac u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_i    (st_q.x),
        .w_i    (st_q.w),
        .acc_o  (acc),
        .emit_o (emit),
        .meet_o (meet_o),
        .tag_o  (tag_o)
    );

    always_comb begin
        st_d   = st_q;
        st_d.x = smp_i;
        st_d.w = wgt_i;
        if (emit) begin
            st_d.o.vld = 1'b1;
            st_d.o.dat = acc;
        end else begin
            st_d.o = res_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_o  = st_q.x;
    assign wgt_o  = st_q.w;
    assign res_o  = st_q.o;
    assign emit_o = emit;
    assign acc_o  = acc;
endmodule

// File: rtl/sr_counterflow_conv.sv
module sr_counterflow_conv
    import cnv_pkg::*;
#(
    parameter int TAPS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp_dat,
    input  logic             wgt_vld,
    input  logic             wgt_tag,
    input  logic [WGT_W-1:0] wgt_dat,
    output logic             res_vld,
    output logic [ACC_W-1:0] res_dat
);
    // An even chain needs one extra weight stage to keep meetings on beats.
    localparam bit SKEW = (TAPS % 2) == 0;

    smp_beat_t smp_lnk [TAPS+1];
    wgt_beat_t wgt_lnk [TAPS+1];
    res_beat_t res_lnk [TAPS+1];
    wgt_beat_t wgt_in;

    logic [TAPS-1:0] cell_emit;
    logic [TAPS-1:0] cell_meet;
    logic [TAPS-1:0] cell_tag;
    logic [TAPS-1:0] cell_lat;
    acc_t [TAPS-1:0] cell_acc;

    always_comb begin
        smp_lnk[0].vld = smp_vld;
        smp_lnk[0].dat = smp_t'(smp_dat);
        wgt_in.vld     = wgt_vld;
        wgt_in.tag     = wgt_tag;
        wgt_in.dat     = wgt_t'(wgt_dat);
        res_lnk[0]     = '0;
    end

    if (SKEW) begin : g_skew
        wgt_beat_t skw_d, skw_q;
        always_comb skw_d = wgt_in;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) skw_q <= '0;
            else        skw_q <= skw_d;
        end
        assign wgt_lnk[TAPS] = skw_q;
    end else begin : g_direct
        assign wgt_lnk[TAPS] = wgt_in;
    end

    for (genvar c = 0; c < TAPS; c++) begin : g_cell
        cnv_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_i  (smp_lnk[c]),
            .wgt_i  (wgt_lnk[c+1]),
            .res_i  (res_lnk[c]),
            .smp_o  (smp_lnk[c+1]),
            .wgt_o  (wgt_lnk[c]),
            .res_o  (res_lnk[c+1]),
            .emit_o (cell_emit[c]),
            .meet_o (cell_meet[c]),
            .tag_o  (cell_tag[c]),
            .acc_o  (cell_acc[c])
        );
        assign cell_lat[c] = res_lnk[c+1].vld;
    end

    assign res_vld = res_lnk[TAPS].vld;
    assign res_dat = res_lnk[TAPS].dat;
endmodule

// File: rtl/sr_counterflow_conv_chk.sv
module sr_counterflow_conv_chk
    import cnv_pkg::*;
#(
    parameter int TAPS = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            res_vld,
    input logic [TAPS-1:0] cell_emit,
    input logic [TAPS-1:0] cell_meet,
    input logic [TAPS-1:0] cell_tag,
    input logic [TAPS-1:0] cell_lat,
    input acc_t [TAPS-1:0] cell_acc
);
    AST_RES_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld); // R7

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !res_vld); // R9

    for (genvar c = 0; c < TAPS; c++) begin : g_cell
        AST_TAG_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (cell_tag[c] && !cell_meet[c]) |=> (cell_acc[c] == '0)); // R5

        AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!cell_tag[c] && !cell_meet[c]) |=> $stable(cell_acc[c])); // R4

        if (c > 0) begin : g_up
            AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
                cell_emit[c] |-> !cell_lat[c-1]); // R8
        end
    end
endmodule

bind sr_counterflow_conv sr_counterflow_conv_chk #(.TAPS(TAPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_vld   (res_vld),
    .cell_emit (cell_emit),
    .cell_meet (cell_meet),
    .cell_tag  (cell_tag),
    .cell_lat  (cell_lat),
    .cell_acc  (cell_acc)
);

// File: tb/test_sr_counterflow_conv.sv
module test_sr_counterflow_conv;
    import cnv_pkg::*;

    localparam int NS   = 40;
    localparam int KA   = 4;
    localparam int KB   = 3;
    localparam int EMAX = 2 * (NS + 3 * KA);

    logic clk = 1'b0;
    logic rst_n;
    always #10 clk = ~clk;

    logic             smp_vld;
    logic [SMP_W-1:0] smp_dat;
    logic             wa_vld, wa_tag, wb_vld, wb_tag;
    logic [WGT_W-1:0] wa_dat, wb_dat;
    logic             ra_vld, rb_vld;
    logic [ACC_W-1:0] ra_dat, rb_dat;

    int errs = 0;
    int chks = 0;
    bit done = 0;

    int w4 [4][4] = '{'{1, 2, 3, 4}, '{-128, 127, -128, -128},
                      '{5, -7, 0, 9}, '{7, -2, 13, -9}};
    int w3 [4][3] = '{'{3, -1, 2}, '{-128, -128, 127},
                      '{-3, 11, 6}, '{4, 8, -5}};

    sr_counterflow_conv #(.TAPS(KA)) i_sr_counterflow_conv (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_dat(smp_dat),
        .wgt_vld(wa_vld), .wgt_tag(wa_tag), .wgt_dat(wa_dat),
        .res_vld(ra_vld), .res_dat(ra_dat));

    sr_counterflow_conv #(.TAPS(KB)) i_sr_counterflow_conv_k3 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_dat(smp_dat),
        .wgt_vld(wb_vld), .wgt_tag(wb_tag), .wgt_dat(wb_dat),
        .res_vld(rb_vld), .res_dat(rb_dat));

    function automatic int xval(int r, int j);
        case (r)
            0:       return j - 20;
            1:       return (j % 2 == 0) ? -128 : 127;
            2:       return ((j * 37) % 251) - 125;
            default: return (j == 10) ? 1 : 0;
        endcase
    endfunction

    function automatic bit xok(int r, int j);
        if (j < 0 || j >= NS) return 1'b0;
        if (r == 2) return !((j % 5 == 2) || (j % 7 == 3)); // R4 gaps
        return 1'b1;
    endfunction

    function automatic int wv(int r, int k, int m);
        return (k == KA) ? w4[r][m] : w3[r][m];
    endfunction

    // R3: y_i = sum w[m]*x_{i+m}, invalid sample slots count as zero (R4)
    function automatic int yexp(int r, int k, int i);
        int s = 0;
        for (int m = 0; m < k; m++)
            if (xok(r, i + m)) s += wv(r, k, m) * xval(r, i + m);
        return s;
    endfunction

    task automatic check(string req, bit ok, int act, int expv);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // R2: slot on even edges; weight slot s = w[s mod K], tag on w[0]
    task automatic drive(int r, int e);
        if (e % 2 == 0) begin
            int s = e / 2;
            smp_vld = xok(r, s);
            smp_dat = SMP_W'(xval(r, s));
            wa_vld  = 1'b1;
            wa_tag  = (s % KA) == 0;
            wa_dat  = WGT_W'(wv(r, KA, s % KA));
            wb_vld  = 1'b1;
            wb_tag  = (s % KB) == 0;
            wb_dat  = WGT_W'(wv(r, KB, s % KB));
        end else begin
            smp_vld = 1'b0; smp_dat = '0;
            wa_vld = 1'b0; wa_tag = 1'b0; wa_dat = '0;
            wb_vld = 1'b0; wb_tag = 1'b0; wb_dat = '0;
        end
    endtask

    // R7: y_i due right after edge 2i+3K; R6: only if slot i valid
    task automatic observe(int r, int e, int k, string dtag, logic v, logic [ACC_W-1:0] d);
        int  i  = (e - 3 * k) / 2;
        bit  ev = (e >= 3 * k) && ((e - 3 * k) % 2 == 0) && xok(r, i);
        int  act = $signed(d);
        check($sformatf("R6 R7 K=%0d edge=%0d valid", k, e), v == ev, int'(v), int'(ev));
        if (ev && v)
            check($sformatf("%s K=%0d y%0d", dtag, k, i), act == yexp(r, k, i), act, yexp(r, k, i));
    endtask

    task automatic run_case(int r, int emax, string dtag);
        rst_n = 1'b0;
        drive(r, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset clears K=4", ra_vld == 1'b0, int'(ra_vld), 0);
        check("R9 reset clears K=3", rb_vld == 1'b0, int'(rb_vld), 0);
        rst_n = 1'b1;
        for (int e = 0; e < emax; e++) begin
            drive(r, e);
            @(posedge clk);
            @(negedge clk);
            observe(r, e, KA, dtag, ra_vld, ra_dat);
            observe(r, e, KB, dtag, rb_vld, rb_dat);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        drive(0, 1);
        run_case(0, EMAX, "R2 R3 ramp");
        run_case(2, 25, "R4 R9 aborted");
        run_case(2, EMAX, "R4 gaps");
        run_case(1, EMAX, "R3 R5 extremes");
        run_case(3, EMAX, "R1 impulse");
        $display("Result: errors=%0d of %0d checks", errs, chks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            chks++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, chks);
            $finish;
        end
    end
endmodule